// File: doc/BRIEF.md
# Multi-Granule Tag Checker

The block checks a tagged pointer against the allocation tags held in a tag memory, one tag per 16-byte granule, for every granule that a memory access touches. The pointer carries a 4-bit tag in bits [59:56]. Tag memory stores two tags per byte: the lower-addressed granule in bits [3:0], the next one in bits [7:4]. The checker reads one tag byte per cycle through a synchronous byte-wide read port. It compares up to two granules per byte and stops at the first granule whose stored tag differs from the pointer tag.

A request is given with a one-cycle `start` pulse. It carries the pointer, the total access size in bytes, the log2 of the element size, and a write flag. Two enable inputs switch checking on separately for the lower and upper address halves, and pointer bit 55 selects the half. A bypass enable lets the pointer's match-all tag skip the check. When the check ends, a one-cycle `done` reports pass or fail and the number of granules that matched before the first miscompare. On a failure it also reports the address of the first failing element, rounded up to the element size.

The access is assumed to lie inside one page. The total size must be at least the element size and no larger than `MAX_BYTES`.

Top module: `tag_granule_checker`

## Requirements
- R1: The first tag byte read is at address ptr[PA_W-1:5]. Pointer bit 4 selects the nibble: bit 4 = 0 starts at bits [3:0], and bit 4 = 1 starts at bits [7:4].
- R2: Tag reads go to consecutive ascending byte addresses, one read per cycle. `tagRd` is only asserted while `busy` is high.
- R3: When every touched granule matches, `pass` = 1 and `matchCount` equals the granule count, ((ptr[3:0] + totalSize − 1) >> 4) + 1. Up to 17 granules are covered (256 bytes, unaligned).
- R4: When a granule miscompares, `pass` = 0 and `matchCount` is the number of granules that matched before the first miscompare. This count is always lower than the granule count.
- R5: On failure, `faultAddr` = ptr + round-up(max(0, matchCount·16 − ptr[3:0]), 2^elemLog2). A failure in the first granule reports the pointer itself. On a pass, `faultAddr` is 0.
- R6: Checking is enabled by `chkEnLo` when ptr[55] = 0 and by `chkEnHi` when ptr[55] = 1. A disabled access passes with `matchCount` = 0, and no tag read is issued.
- R7: When `matchAllEn` = 1 and the pointer tag equals the match-all value (0 when ptr[55] = 0, 0xF when ptr[55] = 1), the access passes with `matchCount` = 0 and no tag read is issued. Any other tag is checked normally.
- R8: Every accepted request produces exactly one `done` pulse. `busy` is low during that pulse. An access that is not checked finishes one cycle after `start`.
- R9: A `start` pulse while `busy` is high is ignored. It produces no result and does not change the result of the running check.
- R10: `resultWrite` returns, together with `done`, the write flag given with the request.
- R11: After reset, `done`, `busy` and `tagRd` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request strobe, accepted when not busy |
| ptr | input | 64 | Tagged pointer: tag in [59:56], half select in [55] |
| totalSize | input | SIZE_W (9) | Access size in bytes |
| elemLog2 | input | ELOG_W (3) | log2 of the element size in bytes |
| isWrite | input | 1 | Write flag of the access |
| chkEnLo | input | 1 | Tag check enable, lower half (ptr[55] = 0) |
| chkEnHi | input | 1 | Tag check enable, upper half (ptr[55] = 1) |
| matchAllEn | input | 1 | Enables the match-all tag bypass |
| busy | output | 1 | Check in progress |
| tagRd | output | 1 | Tag memory read strobe |
| tagAddr | output | PA_W−5 (43) | Tag memory byte address |
| tagData | input | 8 | Tag byte, valid one cycle after `tagRd` |
| done | output | 1 | Result valid for one cycle |
| pass | output | 1 | 1 = all checked granules matched |
| matchCount | output | GCNT_W (5) | Granules matched before the first miscompare |
| faultAddr | output | 64 | Address of the first failing element |
| resultWrite | output | 1 | Write flag of the reported request |

## Verification
Two functions can fall in the same cycle. The first is a `done` pulse that closes one check. The second is acceptance of the next request. A multi-byte check is run, and the next request is driven so that it is sampled on the very cycle its predecessor's `done` is high. One such request is a bypassed access and another is a checked one. Both results must then come out with their own expected values and in order. A separate case shows that the same request is refused while `busy` is high: it must produce no extra `done`.

A second coincidence is a miscompare in the upper nibble of the byte that also holds the last granule. Here the mismatch path and the normal end-of-count path decide in the same comparison cycle, and the result must report the failure with the right matched count.

// File: rtl/tgc_pkg.sv
package tgc_pkg;
  localparam int PTR_W = 64;
  localparam int TAG_W = 4;

  // Strobes from the controller to the datapath
  typedef struct packed {
    logic load;        // capture a new request
    logic skipFinish;  // finish at once without reading tags
    logic run;         // comparison sequence active
    logic runFinish;   // comparison sequence ends this cycle
  } tgcStrobe_t;

  typedef enum logic [0:0] {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } tgcState_t;
endpackage

// File: rtl/tgc_ctrl.sv
module tgc_ctrl
  import tgc_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic       skipNow,
  input  logic       cmpDone,
  output tgcStrobe_t strobe,
  output logic       busy
);
  tgcState_t state, stateNext;

  always_comb begin
    stateNext = state;
    strobe    = '0;
    unique case (state)
      ST_IDLE: begin
        if (start) begin
          strobe.load = 1'b1;
          if (skipNow) strobe.skipFinish = 1'b1;
          else         stateNext = ST_RUN;
        end
      end
      ST_RUN: begin
        strobe.run = 1'b1;
        if (cmpDone) begin
          strobe.runFinish = 1'b1;
          stateNext        = ST_IDLE;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  assign busy = (state == ST_RUN);

  AST_NO_LOAD_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    (busy && start) |=> (busy || $past(cmpDone))); // R9
endmodule

// File: rtl/tgc_dp.sv
module tgc_dp
  import tgc_pkg::*;
#(
  parameter int PA_W      = 48,
  parameter int MAX_BYTES = 256,
  parameter int SIZE_W    = 9,
  parameter int ELOG_W    = 3,
  parameter int GCNT_W    = 5
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  tgcStrobe_t           strobe,
  input  logic [PTR_W-1:0]     ptr,
  input  logic [SIZE_W-1:0]    totalSize,
  input  logic [ELOG_W-1:0]    elemLog2,
  input  logic                 isWrite,
  input  logic                 chkEnLo,
  input  logic                 chkEnHi,
  input  logic                 matchAllEn,
  input  logic [7:0]           tagData,
  output logic                 skipNow,
  output logic                 cmpDone,
  output logic                 tagRd,
  output logic [PA_W-6:0]      tagAddr,
  output logic                 done,
  output logic                 pass,
  output logic [GCNT_W-1:0]    matchCount,
  output logic [PTR_W-1:0]     faultAddr,
  output logic                 resultWrite
);
  localparam int TA_W   = PA_W - 5;
  localparam int MAX_B  = MAX_BYTES / 32 + 2;
  localparam int BCNT_W = $clog2(MAX_B + 1);
  localparam int SUM_W  = SIZE_W + 1;
  localparam int OFF_W  = GCNT_W + 5;

  // request capture
  logic [PTR_W-1:0]  ptrQ;
  logic [ELOG_W-1:0] elemQ;
  logic              writeQ;
  logic [TAG_W-1:0]  tagQ;
  logic [TA_W-1:0]   baseByteQ;
  logic [BCNT_W-1:0] bytesQ, issueIdx;
  logic [GCNT_W-1:0] granQ, cmpLeft, matchedQ;
  logic              oddQ, firstByteQ, dataValid;

  // span of the incoming request
  logic [SUM_W-1:0]  sumGran, sumByte;
  logic [GCNT_W-1:0] granCnt;
  logic [BCNT_W-1:0] byteCnt;
  logic [TAG_W-1:0]  ptrTag;
  logic              halfEn, allTagHit;

  always_comb begin
    sumGran = SUM_W'(ptr[3:0]) + SUM_W'(totalSize) - SUM_W'(1);
    sumByte = SUM_W'(ptr[4:0]) + SUM_W'(totalSize) - SUM_W'(1);
    granCnt = GCNT_W'(sumGran >> 4) + GCNT_W'(1);
    byteCnt = BCNT_W'(sumByte >> 5) + BCNT_W'(1);
    ptrTag  = ptr[59:56];
    halfEn  = ptr[55] ? chkEnHi : chkEnLo;
    allTagHit = matchAllEn && (ptrTag == (ptr[55] ? 4'hF : 4'h0));
    skipNow = !halfEn || allTagHit;
  end

  // read issue: one byte per cycle, ascending
  assign tagRd   = strobe.run && (issueIdx != bytesQ);
  assign tagAddr = baseByteQ + TA_W'(issueIdx);

  // compare both nibbles of the returned byte
  logic       loAct, hiAct, loBad, hiBad, mismatch;
  logic [1:0] used, step;
  logic [GCNT_W-1:0] newMatched;

  always_comb begin
    loAct    = !(firstByteQ && oddQ);
    hiAct    = loAct ? (cmpLeft >= GCNT_W'(2)) : 1'b1;
    loBad    = loAct && (tagData[3:0] != tagQ);
    hiBad    = hiAct && (tagData[7:4] != tagQ);
    mismatch = loBad || hiBad;
    used     = {1'b0, loAct} + {1'b0, hiAct};
    if (loBad)      step = 2'd0;
    else            step = {1'b0, loAct} + {1'b0, hiAct && !hiBad};
    newMatched = matchedQ + GCNT_W'(step);
    cmpDone    = strobe.run && dataValid && (mismatch || (cmpLeft == GCNT_W'(used)));
  end

  // first failing element address
  logic [OFF_W-1:0] rawOff, elemMask, roundOff;
  always_comb begin
    if (newMatched == '0) rawOff = '0;
    else rawOff = OFF_W'({newMatched, 4'b0000}) - OFF_W'(ptrQ[3:0]);
    elemMask = (OFF_W'(1) << elemQ) - OFF_W'(1);
    roundOff = (rawOff + elemMask) & ~elemMask;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ptrQ <= '0; elemQ <= '0; writeQ <= 1'b0; tagQ <= '0;
      baseByteQ <= '0; bytesQ <= '0; issueIdx <= '0;
      granQ <= '0; cmpLeft <= '0; matchedQ <= '0;
      oddQ <= 1'b0; firstByteQ <= 1'b0; dataValid <= 1'b0;
    end else if (strobe.load) begin
      ptrQ       <= ptr;
      elemQ      <= elemLog2;
      writeQ     <= isWrite;
      tagQ       <= ptrTag;
      baseByteQ  <= ptr[PA_W-1:5];
      bytesQ     <= byteCnt;
      issueIdx   <= '0;
      granQ      <= granCnt;
      cmpLeft    <= granCnt;
      matchedQ   <= '0;
      oddQ       <= ptr[4];
      firstByteQ <= 1'b1;
      dataValid  <= 1'b0;
    end else begin
      dataValid <= tagRd && !strobe.runFinish;
      if (tagRd) issueIdx <= issueIdx + BCNT_W'(1);
      if (strobe.run && dataValid) begin
        firstByteQ <= 1'b0;
        cmpLeft    <= cmpLeft - GCNT_W'(used);
        matchedQ   <= newMatched;
      end
    end
  end

  // result registers
  always_ff @(posedge clk) begin
    if (!rstN) begin
      done <= 1'b0; pass <= 1'b0; matchCount <= '0;
      faultAddr <= '0; resultWrite <= 1'b0;
    end else begin
      done <= strobe.skipFinish || strobe.runFinish;
      if (strobe.skipFinish) begin
        pass        <= 1'b1;
        matchCount  <= '0;
        faultAddr   <= '0;
        resultWrite <= isWrite;
      end else if (strobe.runFinish) begin
        pass        <= !mismatch;
        matchCount  <= newMatched;
        faultAddr   <= mismatch ? (ptrQ + PTR_W'(roundOff)) : '0;
        resultWrite <= writeQ;
      end
    end
  end

  AST_RD_ASCEND: assert property (@(posedge clk) disable iff (!rstN)
    (tagRd && $past(tagRd)) |-> (tagAddr == $past(tagAddr) + TA_W'(1))); // R2
  AST_FAULT_AFTER_PTR: assert property (@(posedge clk) disable iff (!rstN)
    (done && !pass) |-> (faultAddr >= ptrQ)); // R5
  AST_FAIL_SHORT: assert property (@(posedge clk) disable iff (!rstN)
    (done && !pass) |-> (matchCount < granQ)); // R4
endmodule

// File: rtl/tag_granule_checker.sv
module tag_granule_checker
  import tgc_pkg::*;
#(
  parameter int PA_W      = 48,
  parameter int MAX_BYTES = 256,
  parameter int ELOG_W    = 3,
  localparam int SIZE_W   = $clog2(MAX_BYTES + 1),
  localparam int MAX_G    = (MAX_BYTES + 15) / 16 + 1,
  localparam int GCNT_W   = $clog2(MAX_G + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [63:0]       ptr,
  input  logic [SIZE_W-1:0] totalSize,
  input  logic [ELOG_W-1:0] elemLog2,
  input  logic              isWrite,
  input  logic              chkEnLo,
  input  logic              chkEnHi,
  input  logic              matchAllEn,
  output logic              busy,
  output logic              tagRd,
  output logic [PA_W-6:0]   tagAddr,
  input  logic [7:0]        tagData,
  output logic              done,
  output logic              pass,
  output logic [GCNT_W-1:0] matchCount,
  output logic [63:0]       faultAddr,
  output logic              resultWrite
);
  tgcStrobe_t strobe;
  logic skipNow, cmpDone;

  tgc_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .start(start), .skipNow(skipNow),
    .cmpDone(cmpDone), .strobe(strobe), .busy(busy)
  );

  tgc_dp #(
    .PA_W(PA_W), .MAX_BYTES(MAX_BYTES), .SIZE_W(SIZE_W),
    .ELOG_W(ELOG_W), .GCNT_W(GCNT_W)
  ) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .ptr(ptr),
    .totalSize(totalSize), .elemLog2(elemLog2), .isWrite(isWrite),
    .chkEnLo(chkEnLo), .chkEnHi(chkEnHi), .matchAllEn(matchAllEn),
    .tagData(tagData), .skipNow(skipNow), .cmpDone(cmpDone),
    .tagRd(tagRd), .tagAddr(tagAddr), .done(done), .pass(pass),
    .matchCount(matchCount), .faultAddr(faultAddr), .resultWrite(resultWrite)
  );

  AST_RD_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    tagRd |-> busy); // R2
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy); // R8
  AST_SKIP_NOREAD: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy && skipNow) |=> (!tagRd && done)); // R7
endmodule

// File: tb/tag_granule_checker_tb_top.sv
module tag_granule_checker_tb_top;
  localparam int PA_W = 48;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [63:0] ptr = '0;
  logic [8:0]  totalSize = '0;
  logic [2:0]  elemLog2 = '0;
  logic        isWrite = 1'b0;
  logic        chkEnLo = 1'b1, chkEnHi = 1'b1, matchAllEn = 1'b0;
  logic        busy, tagRd, done, pass, resultWrite;
  logic [PA_W-6:0] tagAddr;
  logic [7:0]  tagData = '0;
  logic [4:0]  matchCount;
  logic [63:0] faultAddr;

  always #4 clk = ~clk; // 125 MHz

  tag_granule_checker dut_i (
    .clk(clk), .rstN(rstN), .start(start), .ptr(ptr), .totalSize(totalSize),
    .elemLog2(elemLog2), .isWrite(isWrite), .chkEnLo(chkEnLo), .chkEnHi(chkEnHi),
    .matchAllEn(matchAllEn), .busy(busy), .tagRd(tagRd), .tagAddr(tagAddr),
    .tagData(tagData), .done(done), .pass(pass), .matchCount(matchCount),
    .faultAddr(faultAddr), .resultWrite(resultWrite)
  );

  // tag memory model, one-cycle read latency
  logic [7:0] tmem [64];
  always @(posedge clk) if (tagRd) tagData <= tmem[tagAddr[5:0]];

  int nChecks = 0, nFails = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  typedef struct {
    logic        pass;
    logic [4:0]  cnt;
    logic [63:0] fault;
    logic        wr;
    bit          reads;
    logic [PA_W-6:0] firstAddr;
    string       req;
  } item_t;
  item_t sb[$];

  // read-port monitor
  int opReads = 0;
  logic [PA_W-6:0] firstRd, prevRd;
  always @(negedge clk) begin
    if (tagRd) begin
      if (opReads == 0) firstRd = tagAddr;
      else check(tagAddr == prevRd + 1, "R2", "read order", 64'(tagAddr), 64'(prevRd + 1));
      check(busy, "R2", "read outside busy", 64'(busy), 64'd1);
      prevRd = tagAddr;
      opReads++;
    end
  end

  // result monitor / scoreboard
  always @(negedge clk) begin
    if (done) begin
      if (sb.size() == 0) begin
        check(1'b0, "R9", "unexpected done", 64'd1, 64'd0);
      end else begin
        item_t e;
        e = sb.pop_front();
        check(pass == e.pass, e.req, "pass", 64'(pass), 64'(e.pass));
        check(matchCount == e.cnt, e.req, "matchCount", 64'(matchCount), 64'(e.cnt));
        check(faultAddr == e.fault, e.req, "faultAddr", faultAddr, e.fault);
        check(resultWrite == e.wr, "R10", "resultWrite", 64'(resultWrite), 64'(e.wr));
        check(!busy, "R8", "busy during done", 64'(busy), 64'd0);
        if (e.reads) check(firstRd == e.firstAddr, "R1", "first tag address",
                           64'(firstRd), 64'(e.firstAddr));
        else check(opReads == 0, "R6", "reads on unchecked access", 64'(opReads), 64'd0);
      end
    end
  end

  function automatic logic [63:0] mkPtr(input logic [3:0] tag, input bit hi,
                                        input logic [15:0] addr);
    return {4'h0, tag, hi, 39'd0, addr};
  endfunction

  function automatic logic [3:0] granTag(input logic [63:0] g);
    logic [7:0] b;
    b = tmem[(g >> 1) & 63];
    return g[0] ? b[7:4] : b[3:0];
  endfunction

  task automatic setTag(input int g, input logic [3:0] t);
    if (g % 2 == 1) tmem[(g/2) % 64][7:4] = t;
    else            tmem[(g/2) % 64][3:0] = t;
  endtask

  function automatic item_t model(input logic [63:0] p, input int tot, input int el,
                                  input bit wr, input bit enLo, input bit enHi,
                                  input bit ma, input string req);
    item_t e;
    bit en, skip;
    int cnt, n, v, es;
    logic [3:0] t;
    t  = p[59:56];
    en = p[55] ? enHi : enLo;
    skip = !en || (ma && t == (p[55] ? 4'hF : 4'h0));
    e.req = req; e.wr = wr; e.firstAddr = p[PA_W-1:5];
    if (skip) begin
      e.pass = 1; e.cnt = 0; e.fault = 0; e.reads = 0;
      return e;
    end
    e.reads = 1;
    cnt = ((int'(p[3:0]) + tot - 1) / 16) + 1;
    n = 0;
    for (int g = 0; g < cnt; g++) begin
      if (granTag(64'(p[PA_W-1:4]) + 64'(g)) != t) break;
      n++;
    end
    e.cnt = 5'(n);
    if (n == cnt) begin
      e.pass = 1; e.fault = 0;
    end else begin
      es = 1 << el;
      v = n * 16 - int'(p[3:0]);
      if (v < 0 || n == 0) v = 0;
      v = ((v + es - 1) / es) * es;
      e.pass = 0; e.fault = p + 64'(v);
    end
    return e;
  endfunction

  task automatic drive(input logic [63:0] p, input int tot, input int el, input bit wr,
                       input bit enLo, input bit enHi, input bit ma);
    ptr = p; totalSize = 9'(tot); elemLog2 = 3'(el); isWrite = wr;
    chkEnLo = enLo; chkEnHi = enHi; matchAllEn = ma;
    opReads = 0;
    start = 1'b1;
  endtask

  task automatic waitIdle();
    int guard = 0;
    while (sb.size() != 0 && guard < 2000) begin
      @(negedge clk);
      guard++;
    end
    @(negedge clk);
  endtask

  task automatic runOp(input logic [63:0] p, input int tot, input int el, input bit wr,
                       input bit enLo, input bit enHi, input bit ma, input string req);
    @(negedge clk);
    sb.push_back(model(p, tot, el, wr, enLo, enHi, ma, req));
    drive(p, tot, el, wr, enLo, enHi, ma);
    @(negedge clk);
    start = 1'b0;
    waitIdle();
  endtask

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    check(1'b0, "WDOG", "watchdog expired", 64'd0, 64'd1);
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 64; i++) tmem[i] = 8'h55;
    repeat (3) @(negedge clk);
    check(!done && !busy && !tagRd, "R11", "reset state", {61'd0, done, busy, tagRd}, 64'd0);
    rstN = 1'b1;
    @(negedge clk);

    // R3/R1 aligned single granule, even nibble
    runOp(mkPtr(4'h5, 0, 16'h0100), 16, 3, 0, 1, 1, 0, "R3");
    // R1 odd start nibble, 3 granules
    runOp(mkPtr(4'h5, 0, 16'h0118), 32, 2, 0, 1, 1, 0, "R1");
    // R3 64 bytes unaligned, 5 granules
    runOp(mkPtr(4'h5, 0, 16'h0208), 64, 3, 1, 1, 1, 0, "R3");
    // R3 boundary: 256 bytes unaligned, 17 granules
    runOp(mkPtr(4'h5, 0, 16'h0008), 256, 4, 0, 1, 1, 0, "R3");

    // R4/R5 mismatch in third granule, rounding to 8-byte elements
    setTag(32'h12, 4'h9);
    runOp(mkPtr(4'h5, 0, 16'h0104), 64, 3, 0, 1, 1, 0, "R4");
    runOp(mkPtr(4'h5, 0, 16'h0104), 64, 4, 0, 1, 1, 0, "R5");
    // R5 first granule fails: fault is the pointer
    runOp(mkPtr(4'h5, 0, 16'h012C), 8, 2, 0, 1, 1, 0, "R5");
    setTag(32'h12, 4'h5);
    // R4 mismatch in upper nibble of the final byte
    setTag(32'h23, 4'h1);
    runOp(mkPtr(4'h5, 0, 16'h0200), 64, 0, 0, 1, 1, 0, "R4");
    setTag(32'h23, 4'h5);

    // R6 checking disabled for the lower half; upper half enable ignored
    setTag(32'h30, 4'h2);
    runOp(mkPtr(4'h5, 0, 16'h0300), 16, 0, 0, 0, 1, 0, "R6");
    // R6 upper half disabled, lower half enabled, ptr[55]=1 -> unchecked
    runOp(mkPtr(4'h5, 1, 16'h0300), 16, 0, 1, 1, 0, 0, "R6");
    // R6 upper half enabled -> checked and fails
    runOp(mkPtr(4'h5, 1, 16'h0300), 16, 0, 0, 0, 1, 0, "R6");

    // R7 match-all tags
    runOp(mkPtr(4'h0, 0, 16'h0300), 16, 0, 0, 1, 1, 1, "R7");
    runOp(mkPtr(4'hF, 1, 16'h0300), 16, 0, 0, 1, 1, 1, "R7");
    runOp(mkPtr(4'h0, 1, 16'h0300), 16, 0, 0, 1, 1, 1, "R7");
    runOp(mkPtr(4'h0, 0, 16'h0300), 16, 0, 0, 1, 1, 0, "R7");
    setTag(32'h30, 4'h5);

    // R9 start while busy is ignored
    @(negedge clk);
    sb.push_back(model(mkPtr(4'h5, 0, 16'h0008), 256, 4, 1, 1, 1, 0, "R9"));
    drive(mkPtr(4'h5, 0, 16'h0008), 256, 4, 1, 1, 1, 0);
    @(negedge clk);
    start = 1'b0;
    repeat (2) @(negedge clk);
    ptr = mkPtr(4'h0, 0, 16'h0000); chkEnLo = 1'b0; isWrite = 1'b0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    waitIdle();
    repeat (4) @(negedge clk);
    check(sb.size() == 0, "R9", "pending results", 64'(sb.size()), 64'd0);

    // R8 next request sampled in the done cycle: bypassed then checked
    for (int k = 0; k < 2; k++) begin
      @(negedge clk);
      sb.push_back(model(mkPtr(4'h5, 0, 16'h0208), 64, 3, 0, 1, 1, 0, "R8"));
      drive(mkPtr(4'h5, 0, 16'h0208), 64, 3, 0, 1, 1, 0);
      @(negedge clk);
      start = 1'b0;
      while (!done) @(negedge clk);
      if (k == 0) begin
        sb.push_back(model(mkPtr(4'h5, 0, 16'h0000), 32, 0, 1, 0, 1, 0, "R8"));
        drive(mkPtr(4'h5, 0, 16'h0000), 32, 0, 1, 0, 1, 0);
      end else begin
        sb.push_back(model(mkPtr(4'h5, 0, 16'h0118), 32, 2, 1, 1, 1, 0, "R8"));
        drive(mkPtr(4'h5, 0, 16'h0118), 32, 2, 1, 1, 1, 0);
      end
      @(negedge clk);
      start = 1'b0;
      waitIdle();
    end

    repeat (4) @(negedge clk);
    check(sb.size() == 0, "R8", "results outstanding", 64'(sb.size()), 64'd0);
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule